// File: doc/BRIEF.md
# Tree Bitmap Node Index Calculator

This block performs the per-node arithmetic of a multibit-trie route lookup with a four-bit stride. It receives one node as it comes back from memory: a 16-bit child-exit bitmap, a 15-bit stored-prefix bitmap, a child-array base pointer and a next-hop table base pointer. It also receives the four address bits that the search consumes at this level. From these it reports whether the search may descend, the word address of the child node, the position of the longest stored prefix that covers the nibble, and the word address of that prefix's forwarding entry.

The block is purely arithmetic. A search controller presents a node and the matching nibble, then uses the results to pick its next memory read. An optional output register (parameter `REG_OUT`) splits the path from the memory data to the next memory address. Memory access, sequencing and best-match bookkeeping belong to the caller.

Top module: `tbm_node_index`

## Requirements
- R1: The nibble value v (0..15) selects the child-exit bit at position v counted from the most significant bit, which is `i_exit_map[15-v]`. `o_has_child` equals that bit.
- R2: The child index is the number of set bits of `i_exit_map` at positions strictly less than v. Each node occupies two words, so `o_child_addr` = `i_child_base` + 2 x index. This holds whether or not the child exists.
- R3: An all-zero `i_exit_map` marks a terminal node, so `o_has_child` is 0 and `o_child_addr` equals `i_child_base` for every nibble.
- R4: `i_pfx_map` is stored level by level, starting at its MSB (`i_pfx_map[14-p]` holds position p):
  - position 0 is the zero-length prefix;
  - positions 1-2 hold length 1;
  - positions 3-6 hold length 2;
  - positions 7-14 hold length 3.
  A length-L prefix covers the nibble at position (2^L - 1) + (the top L bits of the nibble).
- R5: `o_pfx_pos` is the position of the longest set prefix that covers the nibble. When no set prefix covers it, `o_pfx_pos` is 15.
- R6: The next-hop index is the number of set bits of `i_pfx_map` at positions below `o_pfx_pos`, which is all 15 bits when the position is 15. `o_hop_addr` = `i_hop_base` + that index.
- R7: Both address sums are taken modulo 2^18. A carry out of the low bits of a base pointer propagates into the upper bits, including a wrap from 0x3FFFF to 0x00000.
- R8: With `REG_OUT`=1, every output takes the value that its inputs produced at the previous rising clock edge. Synchronous active-high `rst` clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| i_exit_map | input | 16 | Child-exit bitmap, position 0 at MSB |
| i_pfx_map | input | 15 | Stored-prefix bitmap in level order, position 0 at MSB |
| i_child_base | input | 18 | Word address of the node's first child |
| i_hop_base | input | 18 | Word address of the node's first next-hop entry |
| i_nibble | input | 4 | Address bits consumed at this level |
| o_has_child | output | 1 | A child exists for the nibble |
| o_child_addr | output | 18 | Word address of the selected child node |
| o_pfx_pos | output | 4 | Position of the longest covering prefix, 15 for none |
| o_hop_addr | output | 18 | Word address of the selected next-hop entry |

## Verification
The bench targets these corner cases and the fault each one exposes:
- **Carry propagation.** Pointer sums whose low bits carry into the upper field, including a full wrap, expose a carry-select adder that picks the wrong upper value; the result lands 16 or 32 words off.
- **Longest-match priority.** Prefix maps with several covering prefixes set catch a priority encoder that favours the shorter match. Maps where set bits lie only off the nibble's path catch a search that reports a hit where there is none, instead of position 15 with a count over the whole map.
- **Exit-map extremes.** An all-zero exit map and an all-ones map at nibble 15 catch ones-counting that includes the selected bit itself or counts from the wrong end.
- **Register behaviour.** The register is checked for its one-cycle delay and for its reset value.

// File: rtl/tbm_pkg.sv
package tbm_pkg;

    localparam int STRIDE   = 4;
    localparam int PTR_W    = 18;
    localparam int EXIT_W   = 1 << STRIDE;
    localparam int PFX_W    = EXIT_W - 1;
    localparam int POS_W    = STRIDE;
    localparam int COFF_W   = POS_W + 1;
    localparam logic [POS_W-1:0] NO_MATCH = POS_W'(PFX_W);

    typedef struct packed {
        logic [EXIT_W-1:0] exit_map;
        logic [PFX_W-1:0]  pfx_map;
        logic [PTR_W-1:0]  child_base;
        logic [PTR_W-1:0]  hop_base;
        logic [STRIDE-1:0] nibble;
    } node_in_t;

    typedef struct packed {
        logic              has_child;
        logic [PTR_W-1:0]  child_addr;
        logic [POS_W-1:0]  pfx_pos;
        logic [PTR_W-1:0]  hop_addr;
    } node_out_t;

    function automatic logic [POS_W-1:0] level_base(input int lvl);
        return POS_W'((1 << lvl) - 1);
    endfunction

endpackage

// File: rtl/tbm_cs_add.sv
module tbm_cs_add #(
    parameter int W     = 18,
    parameter int LOW_W = 4
) (
    input  logic [W-1:0]     base,
    input  logic [LOW_W-1:0] offset,
    output logic [W-1:0]     sum
);
    localparam int HI_W = W - LOW_W;

    logic [LOW_W:0]   low_sum;
    logic [HI_W-1:0]  hi_keep;
    logic [HI_W-1:0]  hi_inc;

    always_comb begin
        low_sum = {1'b0, base[LOW_W-1:0]} + {1'b0, offset};
        hi_keep = base[W-1:LOW_W];
        hi_inc  = base[W-1:LOW_W] + HI_W'(1);
        sum     = {(low_sum[LOW_W] ? hi_inc : hi_keep), low_sum[LOW_W-1:0]};
    end

    // R7: the split addition equals a plain modular sum
    always_comb begin
        if (!$isunknown({base, offset})) begin
            p_sum_exact_r7: assert (sum == W'(base + W'(offset)))
                else $error("carry-select sum mismatch");
        end
    end

endmodule

// File: rtl/tbm_child_sel.sv
module tbm_child_sel
    import tbm_pkg::*;
(
    input  logic [EXIT_W-1:0] exit_map,
    input  logic [STRIDE-1:0] nibble,
    output logic              has_child,
    output logic [POS_W-1:0]  child_idx
);
    logic [EXIT_W-1:0] shifted;
    logic [EXIT_W-1:0] left_mask;
    logic [EXIT_W-1:0] left_bits;

    always_comb begin
        shifted   = exit_map << nibble;
        has_child = shifted[EXIT_W-1];
        left_mask = ~({EXIT_W{1'b1}} >> nibble);
        left_bits = exit_map & left_mask;
        child_idx = POS_W'($countones(left_bits));
    end

    always_comb begin
        if (!$isunknown({exit_map, nibble})) begin
            // R3: an empty exit map never yields a child
            p_terminal_no_child_r3: assert (exit_map != '0 || (!has_child && child_idx == '0))
                else $error("terminal node reported a child");
            // R2: a present child's index stays below the total number of exits
            p_idx_bound_r2: assert (!has_child || int'(child_idx) < $countones(exit_map))
                else $error("child index out of range");
        end
    end

endmodule

// File: rtl/tbm_prefix_search.sv
module tbm_prefix_search
    import tbm_pkg::*;
(
    input  logic [PFX_W-1:0]  pfx_map,
    input  logic [STRIDE-1:0] nibble,
    output logic [POS_W-1:0]  pfx_pos,
    output logic [POS_W-1:0]  hop_idx
);
    logic [STRIDE-1:0] lvl_hit;
    logic [POS_W-1:0]  lvl_pos [STRIDE];
    logic [PFX_W-1:0]  below_mask;

    for (genvar L = 0; L < STRIDE; L++) begin : g_level
        always_comb begin
            lvl_pos[L] = level_base(L) + POS_W'(nibble >> (STRIDE - L));
            lvl_hit[L] = pfx_map[POS_W'(PFX_W - 1) - lvl_pos[L]];
        end
    end

    always_comb begin
        pfx_pos = NO_MATCH;
        for (int L = 0; L < STRIDE; L++) begin
            if (lvl_hit[L]) pfx_pos = lvl_pos[L];
        end
        below_mask = ~({PFX_W{1'b1}} >> pfx_pos);
        hop_idx    = POS_W'($countones(pfx_map & below_mask));
    end

    always_comb begin
        if (!$isunknown({pfx_map, nibble})) begin
            // R5: a reported match points at a set bit
            p_hit_bit_set_r5: assert (pfx_pos == NO_MATCH || pfx_map[POS_W'(PFX_W - 1) - pfx_pos])
                else $error("match position not set in map");
            // R5: a stored zero-length prefix always covers the nibble
            p_default_route_r5: assert (!pfx_map[PFX_W-1] || pfx_pos != NO_MATCH)
                else $error("default prefix ignored");
            // R6: the next-hop index never exceeds the number of stored prefixes
            p_hop_count_r6: assert (int'(hop_idx) <= $countones(pfx_map))
                else $error("next-hop index too large");
        end
    end

endmodule

// File: rtl/tbm_node_index.sv
module tbm_node_index
    import tbm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       i_exit_map,
    input  logic [14:0]       i_pfx_map,
    input  logic [17:0]       i_child_base,
    input  logic [17:0]       i_hop_base,
    input  logic [3:0]        i_nibble,
    output logic              o_has_child,
    output logic [17:0]       o_child_addr,
    output logic [3:0]        o_pfx_pos,
    output logic [17:0]       o_hop_addr
);
    node_in_t  nin;
    node_out_t ncomb;
    node_out_t nout;

    logic [POS_W-1:0]  child_idx;
    logic [POS_W-1:0]  hop_idx;

    assign nin = '{exit_map:   i_exit_map,
                   pfx_map:    i_pfx_map,
                   child_base: i_child_base,
                   hop_base:   i_hop_base,
                   nibble:     i_nibble};

    tbm_child_sel u_child (
        .exit_map  (nin.exit_map),
        .nibble    (nin.nibble),
        .has_child (ncomb.has_child),
        .child_idx (child_idx)
    );

    tbm_cs_add #(.W(PTR_W), .LOW_W(COFF_W)) u_child_add (
        .base   (nin.child_base),
        .offset ({child_idx, 1'b0}),
        .sum    (ncomb.child_addr)
    );

    tbm_prefix_search u_pfx (
        .pfx_map (nin.pfx_map),
        .nibble  (nin.nibble),
        .pfx_pos (ncomb.pfx_pos),
        .hop_idx (hop_idx)
    );

    tbm_cs_add #(.W(PTR_W), .LOW_W(POS_W)) u_hop_add (
        .base   (nin.hop_base),
        .offset (hop_idx),
        .sum    (ncomb.hop_addr)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) nout <= '0;
            else     nout <= ncomb;
        end
        // R8: while reset is held, the registered outputs stay cleared
        p_reset_clear_r8: assert property (@(posedge clk) rst |=> (nout == '0 || !$past(rst)))
            else $error("outputs not cleared by reset");
    end else begin : g_comb
        assign nout = ncomb;
    end

    assign o_has_child  = nout.has_child;
    assign o_child_addr = nout.child_addr;
    assign o_pfx_pos    = nout.pfx_pos;
    assign o_hop_addr   = nout.hop_addr;

endmodule

// File: tb/tbm_node_index_bench.sv
module tbm_node_index_bench;

    typedef struct packed {
        logic [15:0] exit_map;
        logic [14:0] pfx_map;
        logic [17:0] child_base;
        logic [17:0] hop_base;
        logic [3:0]  nibble;
        logic        e_has;
        logic [17:0] e_caddr;
        logic [3:0]  e_pos;
        logic [17:0] e_haddr;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        // R1 R2 R5 R6: mixed node, length-2 match
        '{16'h5490, 15'h4602, 18'h00100, 18'h00200, 4'h8, 1'b1, 18'h00106, 4'd5,  18'h00202},
        // R7: carries into the upper bits, hop sum wraps
        '{16'hFFFF, 15'h7FFF, 18'h0001F, 18'h3FFFF, 4'hF, 1'b1, 18'h0003D, 4'd14, 18'h0000D},
        // R3: terminal node with an empty prefix map
        '{16'h0000, 15'h0000, 18'h12345, 18'h2ABCD, 4'h5, 1'b0, 18'h12345, 4'd15, 18'h2ABCD},
        // R4: only the zero-length prefix
        '{16'h0040, 15'h4000, 18'h00010, 18'h0000F, 4'h9, 1'b1, 18'h00010, 4'd0,  18'h0000F},
        // R5 R6 R7: set prefix off the path, child-address wrap
        '{16'h8000, 15'h1000, 18'h3FFFE, 18'h0000F, 4'h3, 1'b0, 18'h00000, 4'd15, 18'h00010},
        // R5: longest wins among several covering prefixes
        '{16'h0020, 15'h7FFB, 18'h00040, 18'h00100, 4'hA, 1'b1, 18'h00040, 4'd5,  18'h00105}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] i_exit_map = '0;
    logic [14:0] i_pfx_map = '0;
    logic [17:0] i_child_base = '0;
    logic [17:0] i_hop_base = '0;
    logic [3:0]  i_nibble = '0;
    logic        o_has_child;
    logic [17:0] o_child_addr;
    logic [3:0]  o_pfx_pos;
    logic [17:0] o_hop_addr;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    tbm_node_index u_tbm_node_index (
        .clk(clk), .rst(rst),
        .i_exit_map(i_exit_map), .i_pfx_map(i_pfx_map),
        .i_child_base(i_child_base), .i_hop_base(i_hop_base),
        .i_nibble(i_nibble),
        .o_has_child(o_has_child), .o_child_addr(o_child_addr),
        .o_pfx_pos(o_pfx_pos), .o_hop_addr(o_hop_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // reference model: walks the maps one position at a time
    function automatic vec_t model(input vec_t v);
        vec_t r = v;
        int cnt = 0;
        int pos = 15;
        for (int p = 0; p < 16; p++) begin
            if (p < int'(v.nibble) && v.exit_map[15-p]) cnt++;
        end
        r.e_has   = v.exit_map[15-int'(v.nibble)];
        r.e_caddr = 18'(v.child_base + 18'(2*cnt));
        for (int L = 0; L < 4; L++) begin
            int q = (1 << L) - 1 + (int'(v.nibble) >> (4 - L));
            if (v.pfx_map[14-q]) pos = q;
        end
        cnt = 0;
        for (int p = 0; p < 15; p++) begin
            if (p < pos && v.pfx_map[14-p]) cnt++;
        end
        r.e_pos   = 4'(pos);
        r.e_haddr = 18'(v.hop_base + 18'(cnt));
        return r;
    endfunction

    task automatic apply(input vec_t v, input string tag);
        @(negedge clk);
        i_exit_map = v.exit_map; i_pfx_map = v.pfx_map;
        i_child_base = v.child_base; i_hop_base = v.hop_base;
        i_nibble = v.nibble;
        @(posedge clk);
        @(negedge clk);
        check({tag, " R1 has_child"}, 32'(o_has_child), 32'(v.e_has));
        check({tag, " R2 child_addr"}, 32'(o_child_addr), 32'(v.e_caddr));
        check({tag, " R5 pfx_pos"}, 32'(o_pfx_pos), 32'(v.e_pos));
        check({tag, " R6 hop_addr"}, 32'(o_hop_addr), 32'(v.e_haddr));
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        i_exit_map = 16'hFFFF; i_pfx_map = 15'h7FFF; i_nibble = 4'hF;
        i_child_base = 18'h1; i_hop_base = 18'h1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset clears every output
        check("R8 reset has_child", 32'(o_has_child), 0);
        check("R8 reset child_addr", 32'(o_child_addr), 0);
        check("R8 reset pfx_pos", 32'(o_pfx_pos), 0);
        check("R8 reset hop_addr", 32'(o_hop_addr), 0);
        rst = 1'b0;

        // R8: new inputs do not reach the outputs before the next edge
        @(posedge clk);
        @(negedge clk);
        i_exit_map = VEC[0].exit_map; i_pfx_map = VEC[0].pfx_map;
        i_child_base = VEC[0].child_base; i_hop_base = VEC[0].hop_base;
        i_nibble = VEC[0].nibble;
        #1;
        check("R8 latency hop_addr", 32'(o_hop_addr), 32'(18'h1 + 18'd14));

        for (int i = 0; i < NVEC; i++) apply(VEC[i], "table");

        // R3: empty exit map at every nibble
        for (int n = 0; n < 16; n++) begin
            vec_t v = '0;
            v.child_base = 18'h2F0F0; v.pfx_map = 15'h2AAA; v.hop_base = 18'h00777;
            v.nibble = 4'(n);
            v = model(v);
            apply(v, "R3 terminal");
            check("R3 no child", 32'(o_has_child), 0);
        end

        // R1 R2 R4 R5 R6 R7: random maps over all nibbles
        for (int k = 0; k < 40; k++) begin
            logic [15:0] em = 16'($urandom);
            logic [14:0] pm = 15'($urandom);
            logic [17:0] cb = 18'($urandom);
            logic [17:0] hb = 18'($urandom);
            for (int n = 0; n < 16; n++) begin
                vec_t v = '0;
                v.exit_map = em; v.pfx_map = pm;
                v.child_base = cb; v.hop_base = hb; v.nibble = 4'(n);
                apply(model(v), "random R4 R7");
            end
        end

        // R8: reset asserted mid-run clears the outputs again
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8 re-reset child_addr", 32'(o_child_addr), 0);
        check("R8 re-reset pfx_pos", 32'(o_pfx_pos), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule